// File: doc/BRIEF.md
# Two-Key Register Write Lock

This block sits between a simple register bus and a bank of protected registers and decides, cycle by cycle, whether a bus write may reach that bank. Out of reset the gate is closed, and every write aimed at the bank is dropped without any error. To open the gate, software writes a first 32-bit magic word to the first key address and then a second magic word to the second key address. Writing zero to either key address closes the gate again. Any other value closes it too.

The key check is an exact compare of the full 32-bit word. The order of the two writes matters. Any key write that breaks the sequence throws away the progress made so far. Reads are never blocked. The read-data path passes the bank's data through for every address except the two key addresses, which always read as zero. The gate state is also available on an output, so the surrounding logic can see whether the bank is open.

Top module: `reg_key_lock`

## Requirements
- R1: After rst_n is asserted, and after it is released, `unlocked` is 0 and the gate is closed.
- R2: While the gate is closed, `bank_we` stays 0 for a write to any address.
- R3: A write of 32'h83E70B13 to address 8'h6C, followed later by a write of 32'h95A4F1E0 to address 8'h70, opens the gate. `unlocked` reads 1 from the clock edge that takes the second write.
- R4: While the gate is open, a write to any address other than 8'h6C and 8'h70 drives `bank_we` high in the same cycle.
- R5: Writing zero to 8'h6C or to 8'h70 while the gate is open closes it from that edge on.
- R6: A wrong value written to 8'h6C after a correct first key discards the progress. A following correct second key then leaves the gate closed.
- R7: A correct second key written before any correct first key leaves the gate closed.
- R8: Writes to 8'h6C and 8'h70 never drive `bank_we`, and a read of either address returns 32'h0.
- R9: For every address other than the two key addresses, `bus_rdata` equals `bank_rdata`, whether the gate is open or closed.
- R10: While the gate is open, a correct first key rewritten to 8'h6C, or a second correct key written to 8'h70, closes the gate. After a correct first key, a correct second key opens it again.
- R11: Writes to non-key addresses made between the two key writes do not disturb the sequence.
- R12: Cycles with `bus_we` low leave the gate state unchanged, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the bus access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bank_rdata | input | 32 | Read data from the protected bank |
| bus_rdata | output | 32 | Read data returned to the bus |
| bank_we | output | 1 | Write enable passed to the protected bank |
| unlocked | output | 1 | High while the gate is open |

## Verification
In a single cycle, the gate both decides whether the current write reaches the bank and updates its own lock state from a key write. The decision always uses the state registered before that edge. The bench provokes this with a protected write in the cycle right after the opening key write, which must pass, and one in the cycle right after a relocking key write, which must be blocked. The key write itself is also judged in its own cycle and must never reach the bank, even while the gate is open.

// File: rtl/reg_key_lock_pkg.sv
package reg_key_lock_pkg;

  typedef enum logic [1:0] {
    LK_SHUT  = 2'd0,
    LK_ARMED = 2'd1,
    LK_OPEN  = 2'd2
  } lk_state_t;

  localparam logic [31:0] LK_KEY_A_DEF = 32'h83E7_0B13;
  localparam logic [31:0] LK_KEY_B_DEF = 32'h95A4_F1E0;

endpackage

// File: rtl/lk_key_decode.sv
module lk_key_decode #(
  parameter int          AW     = 8,
  parameter int          DW     = 32,
  parameter logic [AW-1:0] ADDR_A = 8'h6C,
  parameter logic [AW-1:0] ADDR_B = 8'h70,
  parameter logic [DW-1:0] KEY_A  = 32'h83E7_0B13,
  parameter logic [DW-1:0] KEY_B  = 32'h95A4_F1E0
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          hit_a,
  output logic          hit_b,
  output logic          match_a,
  output logic          match_b
);

  always_comb begin
    hit_a   = (addr == ADDR_A);
    hit_b   = (addr == ADDR_B);
    match_a = (wdata == KEY_A);
    match_b = (wdata == KEY_B);
  end

endmodule

// File: rtl/lk_fsm.sv
module lk_fsm
  import reg_key_lock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic hit_a,
  input  logic hit_b,
  input  logic match_a,
  input  logic match_b,
  output logic unlocked
);

  lk_state_t state_q, state_d;
  logic      st_en;

  // next-state
  always_comb begin
    st_en   = we && (hit_a || hit_b);
    state_d = LK_SHUT;
    if (hit_a) begin
      state_d = match_a ? LK_ARMED : LK_SHUT;
    end else if (hit_b) begin
      state_d = (state_q == LK_ARMED && match_b) ? LK_OPEN : LK_SHUT;
    end
  end

  // state register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_SHUT;
    end else if (st_en) begin
      state_q <= state_d;
    end
  end

  assign unlocked = (state_q == LK_OPEN);

  // R3: gate can only open on the edge that took a good second key
  a_r3_open_needs_key_b : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(we && hit_b && match_b));

  // R5: any first-key write or bad second-key write leaves the gate closed
  a_r5_bad_key_closes : assert property (@(posedge clk) disable iff (!rst_n)
    (we && (hit_a || (hit_b && !match_b))) |=> !unlocked);

  // R12: idle cycles hold the state
  a_r12_idle_holds : assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(state_q));

endmodule

// File: rtl/lk_write_gate.sv
module lk_write_gate #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          key_hit,
  input  logic          unlocked,
  input  logic [DW-1:0] bank_rdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bank_we
);

  always_comb begin
    bank_we   = we && unlocked && !key_hit;
    bus_rdata = key_hit ? '0 : bank_rdata;
  end

  // R2: closed gate never lets a write through
  a_r2_locked_blocks : assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !bank_we);

  // R8: key addresses never reach the bank and read as zero
  a_r8_key_never_passes : assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |-> (!bank_we && bus_rdata == '0));

endmodule

// File: rtl/reg_key_lock.sv
module reg_key_lock
  import reg_key_lock_pkg::*;
#(
  parameter int            AW     = 8,
  parameter int            DW     = 32,
  parameter logic [AW-1:0] ADDR_A = 8'h6C,
  parameter logic [AW-1:0] ADDR_B = 8'h70,
  parameter logic [DW-1:0] KEY_A  = LK_KEY_A_DEF,
  parameter logic [DW-1:0] KEY_B  = LK_KEY_B_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bank_rdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bank_we,
  output logic          unlocked
);

  logic hit_a, hit_b, match_a, match_b;
  logic key_hit;

  lk_key_decode #(
    .AW(AW), .DW(DW), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B),
    .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_dec (
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .hit_a   (hit_a),
    .hit_b   (hit_b),
    .match_a (match_a),
    .match_b (match_b)
  );

  assign key_hit = hit_a || hit_b;

  lk_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (bus_we),
    .hit_a    (hit_a),
    .hit_b    (hit_b),
    .match_a  (match_a),
    .match_b  (match_b),
    .unlocked (unlocked)
  );

  lk_write_gate #(.DW(DW)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (bus_we),
    .key_hit    (key_hit),
    .unlocked   (unlocked),
    .bank_rdata (bank_rdata),
    .bus_rdata  (bus_rdata),
    .bank_we    (bank_we)
  );

endmodule

// File: tb/reg_key_lock_tb_top.sv
module reg_key_lock_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KA = 32'h83E7_0B13;
  localparam logic [31:0] KB = 32'h95A4_F1E0;
  localparam logic [7:0]  AA = 8'h6C;
  localparam logic [7:0]  AB = 8'h70;
  localparam int NV = 23;

  // {addr[8], we, wdata[32], exp_bank_we, exp_unlocked_after, req[4]}
  localparam logic [46:0] VECS [0:NV-1] = '{
    {8'h10, 1'b1, 32'h0000_AAAA, 1'b0, 1'b0, 4'd2},  // R2 locked write dropped
    {AB,    1'b1, KB,            1'b0, 1'b0, 4'd7},  // R7 key B first
    {AA,    1'b1, KA,            1'b0, 1'b0, 4'd7},  // R7 key A, armed only
    {8'h10, 1'b1, 32'h1234_5678, 1'b0, 1'b0, 4'd11}, // R11 write while armed
    {AB,    1'b1, KB,            1'b0, 1'b1, 4'd3},  // R3 opens
    {8'h20, 1'b1, 32'h5555_0000, 1'b1, 1'b1, 4'd4},  // R4 passes
    {AA,    1'b1, 32'h0,         1'b0, 1'b0, 4'd5},  // R5 zero relocks
    {8'h20, 1'b1, 32'h5555_0001, 1'b0, 1'b0, 4'd2},  // R2 right after relock
    {AA,    1'b1, KA,            1'b0, 1'b0, 4'd6},
    {AA,    1'b1, 32'h83E7_0B12, 1'b0, 1'b0, 4'd6},  // R6 wrong key A
    {AB,    1'b1, KB,            1'b0, 1'b0, 4'd6},  // R6 stays closed
    {AA,    1'b1, KA,            1'b0, 1'b0, 4'd3},
    {AB,    1'b1, KB,            1'b0, 1'b1, 4'd3},  // R3
    {AA,    1'b1, KA,            1'b0, 1'b0, 4'd10}, // R10 key A while open
    {AB,    1'b1, KB,            1'b0, 1'b1, 4'd10}, // R10 reopens
    {AB,    1'b1, KB,            1'b0, 1'b0, 4'd10}, // R10 repeat key B closes
    {AA,    1'b1, KA,            1'b0, 1'b0, 4'd3},
    {AB,    1'b1, KB,            1'b0, 1'b1, 4'd8},  // R8 key write no bank_we
    {AA,    1'b0, 32'h0,         1'b0, 1'b1, 4'd12}, // R12 idle at key addr
    {AB,    1'b0, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'd12}, // R12 idle
    {8'h44, 1'b1, 32'hCAFE_F00D, 1'b1, 1'b1, 4'd4},  // R4
    {AB,    1'b1, 32'h0,         1'b0, 1'b0, 4'd5},  // R5 zero to key B
    {8'h44, 1'b1, 32'hCAFE_F00E, 1'b0, 1'b0, 4'd2}   // R2
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bank_rdata;
  logic [31:0] bus_rdata;
  logic        bank_we;
  logic        unlocked;

  int n_run;
  int n_fail;
  bit done;

  reg_key_lock dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bank_rdata (bank_rdata),
    .bus_rdata  (bus_rdata),
    .bank_we    (bank_we),
    .unlocked   (unlocked)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic open_gate();
    @(negedge clk); bus_we = 1'b1; bus_addr = AA; bus_wdata = KA;
    @(negedge clk); bus_addr = AB; bus_wdata = KB;
    @(negedge clk); bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bank_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 unlocked in reset", {31'b0, unlocked}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 unlocked after release", {31'b0, unlocked}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = VECS[i];
      @(negedge clk);
      bus_addr  = v[46:39];
      bus_we    = v[38];
      bus_wdata = v[37:6];
      #1;
      n_run++;
      if (bank_we !== v[5]) begin
        n_fail++;
        $display("FAIL R%0d vec %0d bank_we actual=%b expected=%b", v[3:0], i, bank_we, v[5]);
      end
      @(posedge clk); #1;
      n_run++;
      if (unlocked !== v[4]) begin
        n_fail++;
        $display("FAIL R%0d vec %0d unlocked actual=%b expected=%b", v[3:0], i, unlocked, v[4]);
      end
    end

    // R8 / R9 read path, gate currently closed
    @(negedge clk); bus_we = 1'b0; bank_rdata = 32'hDEAD_BEEF;
    bus_addr = AA; #1; chk("R8 key A reads zero", bus_rdata, 32'h0);
    bus_addr = AB; #1; chk("R8 key B reads zero", bus_rdata, 32'h0);
    bus_addr = 8'h10; #1; chk("R9 closed read passes", bus_rdata, 32'hDEAD_BEEF);
    bus_addr = 8'h6D; #1; chk("R9 near key addr passes", bus_rdata, 32'hDEAD_BEEF);

    open_gate();
    chk("R3 open for read test", {31'b0, unlocked}, 32'd1);
    bank_rdata = 32'h0BAD_F00D;
    bus_addr = 8'h10; #1; chk("R9 open read passes", bus_rdata, 32'h0BAD_F00D);
    bus_addr = AB;    #1; chk("R8 open key read zero", bus_rdata, 32'h0);

    // R1: reset while open closes the gate
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 reset closes", {31'b0, unlocked}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); bus_we = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h1; #1;
    chk("R2 blocked after reset", {31'b0, bank_we}, 32'd0);
    @(negedge clk); bus_we = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule